// File: doc/BRIEF.md
# Receive Frame Queue

This block is the receive-side store of a simple Ethernet MAC. A byte-wide ingress stream delivers whole received frames. Each accepted frame goes into its own slot of a circular queue. The block places a two-byte length header in front of the payload and a CRC-32 trailer after it. Software then drains the queue through one repeated 32-bit data read. Every read returns the next four stored bytes of the oldest frame. When a frame is used up, the read moves on to the next frame in arrival order.

The ingress stream carries no back-pressure. After the final byte of a frame, the block uses the idle gap between frames to write the header and the four trailer bytes. Software sees the number of frames waiting as a count. A sticky receive-available bit is set each time a frame is stored. A control write can turn reception on or off, and the same write can flush everything already queued.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset the pending count is 0, receive-available is 0, reception is disabled and `rd_data` reads 0.
- R2: A frame whose first byte arrives while reception is disabled is discarded entirely and leaves the pending count unchanged.
- R3: A stored frame of n payload bytes reads back as bytes [n+6 low byte, n+6 high byte, payload bytes in order, ...]. Each word carries its lowest-addressed byte in bits 7:0. `rd_data` is valid in the cycle after `rd_en` and holds until the next read.
- R4: The four bytes after the payload are the standard CRC-32 of the payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an initial value of all ones and a final inversion.
- R5: A frame takes ceil((n+6)/4) reads. Bytes of the last word beyond n+6 read as zero. The read after the last word of a frame begins the next frame and lowers the pending count by one.
- R6: A read while the pending count is 0 returns 0 and changes no state.
- R7: Frames are read in arrival order through a ring of 31 slots that wraps. The pending count tracks stored minus fully read frames and never exceeds 31.
- R8: A frame that starts while 31 frames are pending is dropped, and the frames already queued are unaffected.
- R9: A control write with the flush field set clears the pending count and any partly read frame, and aborts a frame being received. The next frame stored afterwards reads from its header.
- R10: Receive-available is set when a frame is stored and cleared by `stat_ack`. A store in the same cycle as the acknowledge wins.
- R11: A frame of up to SLOT_BYTES-6 payload bytes (122 by default) is stored. A longer frame is dropped whole.
- R12: A frame stored in the same cycle as the final word read of another frame leaves the pending count unchanged.
- R13: After the last byte of a frame, `in_valid` stays low for at least 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress byte valid |
| in_data | input | 8 | Ingress byte |
| in_last | input | 1 | Marks the final byte of a frame |
| ctl_we | input | 1 | Control register write strobe |
| ctl_rx_en | input | 1 | Written receive-enable field |
| ctl_flush | input | 1 | Written flush field (acts once, not stored) |
| rd_en | input | 1 | Data word read strobe |
| rd_data | output | 32 | Read word, valid the cycle after `rd_en` |
| pend_count | output | 5 | Frames stored and not fully read |
| rx_avail | output | 1 | Sticky frame-stored status |
| stat_ack | input | 1 | Clears `rx_avail` |

## Verification
The bench goes after byte-lane packing and trailer placement with a known nine-byte vector. A design that reversed byte order or seeded the CRC wrongly would read back a different last word. Frames of 1 to 4 bytes expose a wrong pad mask, which would leak stale RAM bytes, and a wrong word count, which would misalign every following frame. Filling all 31 slots from a nonzero read pointer tests the wrap and the drop when full; an off-by-one there would corrupt the oldest frame or report 32. A store timed to land on the same edge as a final read, and a flush in the middle of a frame, target a count that loses or gains a frame and a reader that resumes stale state.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [2:0] {
    ING_IDLE,
    ING_RECV,
    ING_DISCARD,
    ING_HDR,
    ING_CRC
  } ing_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  // One byte of reflected CRC-32, LSB-first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxq_crc32.sv
module rxq_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        restart,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  import rxq_pkg::*;

  logic [31:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (step) acc_d = crc32_byte(restart ? CRC_SEED : acc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= CRC_SEED;
    else if (step) acc_q <= acc_d;
  end

  assign crc_out = ~acc_q;

endmodule

// File: rtl/rxq_lane_ram.sv
module rxq_lane_ram #(
  parameter int DEPTH = 992,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_lane_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_q
);
  // Four independent byte lanes so one byte or a pair can be written alone.
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (wr_lane_en[g]) mem[wr_addr] <= wr_data[8*g +: 8];
    end

    always_ff @(posedge clk) begin
      if (rd_en) q <= mem[rd_addr];
    end

    assign rd_q[8*g +: 8] = q;
  end

endmodule

// File: rtl/rxq_ingress.sv
module rxq_ingress #(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SLOT_W  = $clog2(NUM_SLOTS),
  localparam int CNT_W   = $clog2(NUM_SLOTS + 1),
  localparam int OFF_W   = $clog2(SLOT_BYTES),
  localparam int WORD_W  = OFF_W - 2,
  localparam int LEN_W   = OFF_W + 1,
  localparam int AW      = SLOT_W + WORD_W,
  localparam int MAX_PAY = SLOT_BYTES - 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              rx_en,
  input  logic              flush,
  input  logic [CNT_W-1:0]  pend,
  input  logic [SLOT_W-1:0] rd_ptr,
  output logic [AW-1:0]     wr_addr,
  output logic [3:0]        wr_lane_en,
  output logic [31:0]       wr_data,
  output logic              commit,
  output logic [SLOT_W-1:0] commit_slot,
  output logic [LEN_W-1:0]  commit_len
);
  import rxq_pkg::*;

  ing_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        idx_q, idx_d;

  logic              crc_step, crc_restart;
  logic [31:0]       crc_val;
  logic              byte_we, hdr_we;
  logic [OFF_W-1:0]  wr_off;
  logic [7:0]        wr_byte;
  logic [SLOT_W:0]   slot_sum;
  logic [SLOT_W-1:0] free_slot, wr_slot;
  logic [15:0]       hdr_len;

  // Slot behind the last pending frame, modulo the ring size.
  assign slot_sum  = {1'b0, rd_ptr} + (SLOT_W+1)'(pend);
  assign free_slot = (slot_sum >= (SLOT_W+1)'(NUM_SLOTS))
                     ? SLOT_W'(slot_sum - (SLOT_W+1)'(NUM_SLOTS))
                     : SLOT_W'(slot_sum);
  assign wr_slot   = (state_q == ING_IDLE) ? free_slot : slot_q;
  assign hdr_len   = 16'(cnt_q) + 16'd6;

  always_comb begin
    state_d     = state_q;
    slot_d      = slot_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    crc_step    = 1'b0;
    crc_restart = 1'b0;
    byte_we     = 1'b0;
    hdr_we      = 1'b0;
    wr_off      = '0;
    wr_byte     = in_data;
    commit      = 1'b0;
    unique case (state_q)
      ING_IDLE: begin
        if (in_valid) begin
          if (flush || !rx_en || (int'(pend) >= NUM_SLOTS)) begin
            state_d = in_last ? ING_IDLE : ING_DISCARD;
          end else begin
            slot_d      = free_slot;
            cnt_d       = OFF_W'(1);
            byte_we     = 1'b1;
            wr_off      = OFF_W'(2);
            crc_step    = 1'b1;
            crc_restart = 1'b1;
            state_d     = in_last ? ING_HDR : ING_RECV;
          end
        end
      end
      ING_RECV: begin
        if (flush) begin
          state_d = (in_valid && in_last) ? ING_IDLE : ING_DISCARD;
        end else if (in_valid) begin
          if (int'(cnt_q) == MAX_PAY) begin
            state_d = in_last ? ING_IDLE : ING_DISCARD;
          end else begin
            byte_we  = 1'b1;
            wr_off   = cnt_q + OFF_W'(2);
            cnt_d    = cnt_q + OFF_W'(1);
            crc_step = 1'b1;
            state_d  = in_last ? ING_HDR : ING_RECV;
          end
        end
      end
      ING_DISCARD: begin
        if (in_valid && in_last) state_d = ING_IDLE;
      end
      ING_HDR: begin
        if (flush) begin
          state_d = ING_IDLE;
        end else begin
          hdr_we  = 1'b1;
          idx_d   = 2'd0;
          state_d = ING_CRC;
        end
      end
      ING_CRC: begin
        if (flush) begin
          state_d = ING_IDLE;
        end else begin
          byte_we = 1'b1;
          wr_off  = cnt_q + OFF_W'(2) + OFF_W'(idx_q);
          wr_byte = crc_val[8*idx_q +: 8];
          idx_d   = idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            commit  = 1'b1;
            state_d = ING_IDLE;
          end
        end
      end
      default: state_d = ING_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ING_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  rxq_crc32 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (crc_step),
    .restart (crc_restart),
    .din     (in_data),
    .crc_out (crc_val)
  );

  assign wr_addr     = {wr_slot, hdr_we ? WORD_W'(0) : wr_off[OFF_W-1:2]};
  assign wr_lane_en  = hdr_we ? 4'b0011 : (byte_we ? (4'b0001 << wr_off[1:0]) : 4'b0000);
  assign wr_data     = hdr_we ? {16'd0, hdr_len} : {4{wr_byte}};
  assign commit_slot = slot_q;
  assign commit_len  = LEN_W'(cnt_q) + LEN_W'(6);

  a_r13_gap_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ING_HDR || state_q == ING_CRC) |-> !in_valid)
    else $error("ingress byte arrived while trailer was being written");

  a_r8_commit_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (int'(pend) < NUM_SLOTS))
    else $error("frame stored into a full ring");

  a_r11_len_fits_slot: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (int'(commit_len) <= SLOT_BYTES))
    else $error("stored frame overruns its slot");

endmodule

// File: rtl/rxq_drain.sv
module rxq_drain #(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int OFF_W  = $clog2(SLOT_BYTES),
  localparam int WORD_W = OFF_W - 2,
  localparam int LEN_W  = OFF_W + 1,
  localparam int AW     = SLOT_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              flush,
  input  logic [CNT_W-1:0]  pend,
  input  logic              commit,
  input  logic [SLOT_W-1:0] commit_slot,
  input  logic [LEN_W-1:0]  commit_len,
  output logic [SLOT_W-1:0] rd_ptr,
  output logic              pop,
  output logic              ram_rd_en,
  output logic [AW-1:0]     ram_rd_addr,
  output logic [3:0]        byte_mask
);
  logic [LEN_W-1:0]  len_tab [NUM_SLOTS];

  logic [SLOT_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LEN_W-1:0]  rem_q, rem_d, cur_rem;
  logic [WORD_W-1:0] word_q, word_d, cur_word;
  logic              active_q, active_d;
  logic [3:0]        mask_q, mask_d, lane_ok;
  logic              take, last_word;

  always_ff @(posedge clk) begin
    if (commit) len_tab[commit_slot] <= commit_len;
  end

  assign take      = rd_en && (pend != '0) && !flush;
  assign cur_rem   = active_q ? rem_q  : len_tab[rd_ptr_q];
  assign cur_word  = active_q ? word_q : '0;
  assign last_word = (cur_rem <= LEN_W'(4));

  always_comb begin
    for (int i = 0; i < 4; i++) lane_ok[i] = (cur_rem > LEN_W'(i));
  end

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    rem_d    = rem_q;
    word_d   = word_q;
    active_d = active_q;
    mask_d   = mask_q;
    if (rd_en) mask_d = take ? lane_ok : 4'b0000;
    if (flush) begin
      active_d = 1'b0;
      word_d   = '0;
    end else if (take) begin
      if (last_word) begin
        active_d = 1'b0;
        word_d   = '0;
        rd_ptr_d = (rd_ptr_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : rd_ptr_q + SLOT_W'(1);
      end else begin
        active_d = 1'b1;
        rem_d    = cur_rem - LEN_W'(4);
        word_d   = cur_word + WORD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      rem_q    <= '0;
      word_q   <= '0;
      active_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      rem_q    <= rem_d;
      word_q   <= word_d;
      active_q <= active_d;
      mask_q   <= mask_d;
    end
  end

  assign rd_ptr      = rd_ptr_q;
  assign pop         = take && last_word;
  assign ram_rd_en   = take;
  assign ram_rd_addr = {rd_ptr_q, cur_word};
  assign byte_mask   = mask_q;

  a_r7_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_ptr_q) < NUM_SLOTS)
    else $error("read pointer left the ring");

  a_r5_partial_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (rem_q != '0 && int'(rem_q) < SLOT_BYTES))
    else $error("partly read frame has an impossible remainder");

  a_r6_pop_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (pend != '0))
    else $error("frame consumed with none pending");

endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int OFF_W  = $clog2(SLOT_BYTES),
  localparam int WORD_W = OFF_W - 2,
  localparam int LEN_W  = OFF_W + 1,
  localparam int AW     = SLOT_W + WORD_W,
  localparam int DEPTH  = NUM_SLOTS * (SLOT_BYTES / 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             ctl_we,
  input  logic             ctl_rx_en,
  input  logic             ctl_flush,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic [CNT_W-1:0] pend_count,
  output logic             rx_avail,
  input  logic             stat_ack
);
  logic              rx_en_q;
  logic              flush;
  logic [CNT_W-1:0]  pend_q, pend_d;
  logic              avail_q, avail_d;

  logic [AW-1:0]     wr_addr, rd_addr;
  logic [3:0]        wr_lane_en, byte_mask;
  logic [31:0]       wr_data, ram_q;
  logic              ram_rd_en;
  logic              commit, pop;
  logic [SLOT_W-1:0] commit_slot, rd_ptr;
  logic [LEN_W-1:0]  commit_len;

  assign flush = ctl_we && ctl_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_en_q <= 1'b0;
    else if (ctl_we) rx_en_q <= ctl_rx_en;
  end

  always_comb begin
    pend_d = pend_q;
    if (flush)             pend_d = '0;
    else if (commit && !pop) pend_d = pend_q + CNT_W'(1);
    else if (pop && !commit) pend_d = pend_q - CNT_W'(1);
    avail_d = avail_q;
    if (commit)        avail_d = 1'b1;
    else if (stat_ack) avail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      avail_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      avail_q <= avail_d;
    end
  end

  rxq_ingress #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_ing (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .rx_en       (rx_en_q),
    .flush       (flush),
    .pend        (pend_q),
    .rd_ptr      (rd_ptr),
    .wr_addr     (wr_addr),
    .wr_lane_en  (wr_lane_en),
    .wr_data     (wr_data),
    .commit      (commit),
    .commit_slot (commit_slot),
    .commit_len  (commit_len)
  );

  rxq_drain #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_drn (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .flush       (flush),
    .pend        (pend_q),
    .commit      (commit),
    .commit_slot (commit_slot),
    .commit_len  (commit_len),
    .rd_ptr      (rd_ptr),
    .pop         (pop),
    .ram_rd_en   (ram_rd_en),
    .ram_rd_addr (rd_addr),
    .byte_mask   (byte_mask)
  );

  rxq_lane_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk        (clk),
    .wr_addr    (wr_addr),
    .wr_lane_en (wr_lane_en),
    .wr_data    (wr_data),
    .rd_en      (ram_rd_en),
    .rd_addr    (rd_addr),
    .rd_q       (ram_q)
  );

  assign rd_data    = ram_q & {{8{byte_mask[3]}}, {8{byte_mask[2]}},
                               {8{byte_mask[1]}}, {8{byte_mask[0]}}};
  assign pend_count = pend_q;
  assign rx_avail   = avail_q;

  a_r7_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_q) <= NUM_SLOTS)
    else $error("pending count above ring size");

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_q == '0))
    else $error("flush left frames pending");

  a_r10_store_sets_avail: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rx_avail)
    else $error("stored frame did not raise receive-available");

  a_r12_store_and_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pop) |=> $stable(pend_q))
    else $error("simultaneous store and pop changed the count");

  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pend_q == '0) |=> (rd_data == 32'd0))
    else $error("read of empty queue returned data");

endmodule

// File: tb/sim_rx_frame_queue.sv
`timescale 1ns/100ps
module sim_rx_frame_queue;
  localparam int NS = 31;
  localparam int SB = 128;
  localparam int MAXP = SB - 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        ctl_we = 1'b0, ctl_rx_en = 1'b0, ctl_flush = 1'b0;
  logic        rd_en = 1'b0, stat_ack = 1'b0;
  logic [31:0] rd_data;
  logic [4:0]  pend_count;
  logic        rx_avail;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_frame_queue #(.NUM_SLOTS(NS), .SLOT_BYTES(SB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .ctl_we(ctl_we), .ctl_rx_en(ctl_rx_en), .ctl_flush(ctl_flush), .rd_en(rd_en),
    .rd_data(rd_data), .pend_count(pend_count), .rx_avail(rx_avail), .stat_ack(stat_ack)
  );

  function automatic logic [7:0] pay(int seed, int k);
    if (seed == 0) return 8'(8'h31 + k);
    return 8'(seed * 29 + k * 7 + 3);
  endfunction

  function automatic logic [31:0] crc_of(int n, int seed);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int j = 0; j < n; j++) begin
      c = c ^ {24'd0, pay(seed, j)};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] exp_byte(int n, int seed, int k);
    int total = n + 6;
    logic [31:0] c;
    if (k >= total) return 8'd0;
    if (k == 0) return 8'(total);
    if (k == 1) return 8'(total >> 8);
    if (k < n + 2) return pay(seed, k - 2);
    c = crc_of(n, seed);
    return c[8*(k-n-2) +: 8];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl_write(bit en, bit fl);
    @(negedge clk); ctl_we = 1; ctl_rx_en = en; ctl_flush = fl;
    @(negedge clk); ctl_we = 0; ctl_flush = 0;
  endtask

  task automatic send_frame(int n, int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_valid = 1; in_data = pay(seed, k); in_last = (k == n - 1);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] w);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; w = rd_data;
  endtask

  task automatic read_frame(int n, int seed, string req);
    logic [31:0] w, e;
    for (int i = 0; i < (n + 9) / 4; i++) begin
      read_word(w);
      e = {exp_byte(n, seed, 4*i+3), exp_byte(n, seed, 4*i+2),
           exp_byte(n, seed, 4*i+1), exp_byte(n, seed, 4*i)};
      chk(w == e, req, w, e);
    end
  endtask

  task automatic t_reset;  // R1
    chk(pend_count == 0, "R1 pend", 32'(pend_count), 0);
    chk(rx_avail == 0, "R1 avail", 32'(rx_avail), 0);
    chk(rd_data == 0, "R1 data", rd_data, 0);
  endtask

  task automatic t_disabled;  // R2
    send_frame(12, 3);
    chk(pend_count == 0, "R2 disabled drop", 32'(pend_count), 0);
    chk(rx_avail == 0, "R2 no status", 32'(rx_avail), 0);
  endtask

  task automatic t_known_vector;  // R3 R4
    logic [31:0] w;
    ctl_write(1, 0);
    send_frame(9, 0);
    chk(pend_count == 1, "R3 stored", 32'(pend_count), 1);
    read_word(w); chk(w == 32'h3231000F, "R3 header word", w, 32'h3231000F);
    read_word(w); chk(w == 32'h36353433, "R3 payload word", w, 32'h36353433);
    read_word(w); chk(w == 32'h26393837, "R4 crc low byte", w, 32'h26393837);
    read_word(w); chk(w == 32'h00CBF439, "R4 crc tail", w, 32'h00CBF439);
    chk(pend_count == 0, "R5 popped", 32'(pend_count), 0);
    chk(rd_data == 32'h00CBF439, "R3 data held", rd_data, 32'h00CBF439);
  endtask

  task automatic t_short_frames;  // R5 R7
    for (int i = 1; i <= 4; i++) send_frame(i, 20 + i);
    chk(pend_count == 4, "R7 count four", 32'(pend_count), 4);
    for (int i = 1; i <= 4; i++) begin
      read_frame(i, 20 + i, "R5 short frame");
      chk(pend_count == 5'(4 - i), "R5 count drop", 32'(pend_count), 32'(4 - i));
    end
  endtask

  task automatic t_empty_read;  // R6
    logic [31:0] w;
    read_word(w);
    chk(w == 0, "R6 empty data", w, 0);
    chk(pend_count == 0, "R6 empty count", 32'(pend_count), 0);
    send_frame(7, 31);
    read_frame(7, 31, "R6 no state moved");
  endtask

  task automatic t_status;  // R10
    @(negedge clk); stat_ack = 1;
    @(negedge clk); stat_ack = 0;
    chk(rx_avail == 0, "R10 ack clears", 32'(rx_avail), 0);
    send_frame(5, 40);
    chk(rx_avail == 1, "R10 store sets", 32'(rx_avail), 1);
    read_frame(5, 40, "R10 frame");
  endtask

  task automatic t_full_ring;  // R7 R8
    for (int i = 0; i < NS; i++) send_frame(1 + i, 100 + i);
    chk(pend_count == 31, "R7 ring full", 32'(pend_count), 31);
    send_frame(6, 77);
    chk(pend_count == 31, "R8 drop when full", 32'(pend_count), 31);
    for (int i = 0; i < NS; i++) read_frame(1 + i, 100 + i, "R8 order kept");
    chk(pend_count == 0, "R7 ring drained", 32'(pend_count), 0);
  endtask

  task automatic t_oversize;  // R11
    send_frame(MAXP + 1, 55);
    chk(pend_count == 0, "R11 oversize dropped", 32'(pend_count), 0);
    send_frame(MAXP, 56);
    chk(pend_count == 1, "R11 max stored", 32'(pend_count), 1);
    read_frame(MAXP, 56, "R11 max frame");
  endtask

  task automatic t_flush;  // R9
    logic [31:0] w;
    send_frame(20, 5);
    send_frame(8, 6);
    read_word(w);
    ctl_write(1, 1);
    chk(pend_count == 0, "R9 count cleared", 32'(pend_count), 0);
    read_word(w);
    chk(w == 0, "R9 read after flush", w, 0);
    send_frame(10, 7);
    read_frame(10, 7, "R9 fresh frame");
  endtask

  task automatic t_concurrent;  // R12
    logic [31:0] w, e;
    send_frame(10, 9);
    for (int i = 0; i < 3; i++) read_word(w);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); in_valid = 1; in_data = pay(10, k); in_last = (k == 5);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    repeat (3) @(negedge clk);
    chk(pend_count == 1, "R12 before", 32'(pend_count), 1);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; w = rd_data;
    e = {exp_byte(10, 9, 15), exp_byte(10, 9, 14), exp_byte(10, 9, 13), exp_byte(10, 9, 12)};
    chk(w == e, "R12 last word", w, e);
    chk(pend_count == 1, "R12 count kept", 32'(pend_count), 1);
    read_frame(6, 10, "R12 new frame");
    chk(pend_count == 0, "R12 drained", 32'(pend_count), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_known_vector();
    t_short_frames();
    t_empty_read();
    t_status();
    t_full_ring();
    t_oversize();
    t_flush();
    t_concurrent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule